// File: doc/BRIEF.md
# Addressed Nibble Control Bus Endpoint

This block is the far end of a small parallel control bus. A host presents a 4-bit slot address and a 4-bit data nibble, then pulses one of two strobes. A rising edge on the write strobe stores the nibble in the addressed slot. A rising edge on the read strobe returns the contents of the addressed slot on a read-data port. There are sixteen slots. The low slots are output latches whose bits drive mode and switch control lines elsewhere in the chip. The top `NUM_IN` slots are read-only status ports. These ports sample asynchronous flags such as over-temperature, signal-present or overload through a two-stage synchroniser.

Both strobes are sampled in the block clock domain, and only their rising edges act. A system that needs two independent buses places two instances of this block, each with its own sixteen slots.

Top module: `nbus_top`

## Requirements
- R1: While reset is high and on the first clock after it, every output latch in `ctl_out` reads zero and `rd_data` is zero.
- R2: A rising edge of `wr_en`, seen at a clock edge, stores `wr_data` into output slot `addr`. Slot k occupies bits `[4k+3:4k]` of `ctl_out`, and the new value appears just after that same clock edge.
- R3: A write changes only the addressed slot. All other nibbles of `ctl_out` keep their values.
- R4: Changes on `addr` and `wr_data` have no effect on `ctl_out` unless a new `wr_en` rising edge occurs. Holding `wr_en` high while the address or data changes writes nothing further.
- R5: A write to a status address (slots `16-NUM_IN` to 15, which are 12 to 15 by default) is ignored. `ctl_out` is unchanged and a read of that slot still returns the status nibble.
- R6: A rising edge of `rd_en` at a clock edge loads the addressed output latch into `rd_data`, visible just after that edge.
- R7: A read of status slot `16-NUM_IN+j` returns bits `[4j+3:4j]` of `status_in` as they were two clock edges before the read edge. A value that changed one edge earlier still reads as the old value.
- R8: `rd_data` holds its value for as long as `rd_en` stays high, even if `addr` or the slot contents change. It returns to zero at the first clock edge that samples `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Slot address |
| wr_data | input | 4 | Nibble to write |
| wr_en | input | 1 | Write strobe; its rising edge acts |
| rd_en | input | 1 | Read strobe; its rising edge acts |
| status_in | input | 16 | Asynchronous status flags, four bits per status slot |
| ctl_out | output | 48 | Output latches, four bits per output slot |
| rd_data | output | 4 | Read-back nibble, zero when idle |

## Verification
The assertions assume that both strobes are already in the clock domain and are clean levels. They also assume that `wr_en` and `rd_en` hold steady between edges, so one edge-detected transfer is one host transfer. The bench drives every input one time unit after a rising clock edge and holds each strobe high for at least one full cycle. Status inputs change only between reads, except in the one check that deliberately reads a value just after it changes.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;
    localparam int NSLOT  = 1 << ADDR_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ADDR_W-1:0] slot_t;

    typedef struct packed {
        slot_t slot;
        nib_t  data;
    } bus_req_t;

    function automatic logic slot_is_status(input slot_t s, input int num_out);
        return int'(s) >= num_out;
    endfunction
endpackage

// File: rtl/nbus_edge.sv
module nbus_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/nbus_latch_bank.sv
module nbus_latch_bank
    import nbus_pkg::*;
#(
    parameter int NUM_OUT = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_pulse,
    input  bus_req_t                 req,
    output logic [NUM_OUT*NIB_W-1:0] q
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
        logic hit;
        assign hit = wr_pulse && (req.slot == slot_t'(k));

        always_ff @(posedge clk) begin
            if (rst)      q[k*NIB_W +: NIB_W] <= '0;
            else if (hit) q[k*NIB_W +: NIB_W] <= req.data;
        end
    end
endmodule

// File: rtl/nbus_sync.sv
module nbus_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/nbus_top.sv
module nbus_top
    import nbus_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int NUM_OUT = NSLOT - NUM_IN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NIB_W-1:0]         wr_data,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [NUM_IN*NIB_W-1:0]  status_in,
    output logic [NUM_OUT*NIB_W-1:0] ctl_out,
    output logic [NIB_W-1:0]         rd_data
);
    bus_req_t req;
    logic     wr_rise, rd_rise, wr_ok;
    logic [NUM_IN*NIB_W-1:0] stat_s;
    nib_t     sel_nib;

    assign req.slot = addr;
    assign req.data = wr_data;
    assign wr_ok    = wr_rise && !slot_is_status(addr, NUM_OUT);

    nbus_edge u_wr_edge (.clk(clk), .rst(rst), .level(wr_en), .rise(wr_rise));
    nbus_edge u_rd_edge (.clk(clk), .rst(rst), .level(rd_en), .rise(rd_rise));

    nbus_latch_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk(clk), .rst(rst), .wr_pulse(wr_ok), .req(req), .q(ctl_out)
    );

    nbus_sync #(.WIDTH(NUM_IN*NIB_W)) u_sync (
        .clk(clk), .rst(rst), .async_in(status_in), .sync_out(stat_s)
    );

    always_comb begin
        sel_nib = '0;
        for (int s = 0; s < NUM_OUT; s++)
            if (addr == slot_t'(s)) sel_nib = ctl_out[s*NIB_W +: NIB_W];
        for (int j = 0; j < NUM_IN; j++)
            if (addr == slot_t'(NUM_OUT + j)) sel_nib = stat_s[j*NIB_W +: NIB_W];
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_rise) rd_data <= sel_nib;
        else if (!rd_en) rd_data <= '0;
    end
endmodule

// File: rtl/nbus_chk.sv
module nbus_chk
    import nbus_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int NUM_OUT = NSLOT - NUM_IN
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        addr,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [NUM_OUT*NIB_W-1:0] ctl_out,
    input logic [NIB_W-1:0]         rd_data
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ctl_out == '0 && rd_data == '0));

    a_r4_no_strobe_no_change: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_out));

    a_r4_held_strobe_no_change: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |=> $stable(ctl_out));

    a_r5_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(addr) >= NUM_OUT) |=> $stable(ctl_out));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |=> $stable(rd_data));
endmodule

bind nbus_top nbus_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .ctl_out(ctl_out), .rd_data(rd_data)
);

// File: tb/tb_nbus_top.sv
module tb_nbus_top;
    localparam int CLK_P   = 10;
    localparam int NUM_IN  = 4;
    localparam int NUM_OUT = 16 - NUM_IN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] addr = '0, wr_data = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [NUM_IN*4-1:0]  status_in = '0;
    logic [NUM_OUT*4-1:0] ctl_out;
    logic [3:0] rd_data;

    logic [NUM_OUT*4-1:0] exp_ctl = '0;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    nbus_top #(.NUM_IN(NUM_IN)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .status_in(status_in), .ctl_out(ctl_out), .rd_data(rd_data)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk_ctl(input string req);
        total++;
        if (ctl_out !== exp_ctl) begin
            bad++;
            $display("FAIL %s ctl_out actual=%h expected=%h", req, ctl_out, exp_ctl);
        end
    endtask

    task automatic chk_rd(input string req, input logic [3:0] e);
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, e);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        step();
        if (int'(a) < NUM_OUT) exp_ctl[int'(a)*4 +: 4] = d;
        wr_en = 1'b0;
        step();
    endtask

    task automatic do_read(input logic [3:0] a, output logic [3:0] v);
        addr = a; rd_en = 1'b1;
        step();
        v = rd_data;
        rd_en = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] v;
        step(); step();
        chk_ctl("R1"); chk_rd("R1", 4'h0);
        rst = 1'b0;
        step();
        chk_ctl("R1"); chk_rd("R1", 4'h0);

        // R2/R3: every value into every output slot, whole vector checked
        for (int s = 0; s < NUM_OUT; s++) begin
            for (int d = 0; d < 16; d++) begin
                addr = 4'(s); wr_data = 4'((d * 7 + s) & 15); wr_en = 1'b1;
                step();
                exp_ctl[s*4 +: 4] = 4'((d * 7 + s) & 15);
                chk_ctl("R2 R3 write");
                wr_en = 1'b0;
                step();
            end
        end
        for (int s = 0; s < NUM_OUT; s++) do_write(4'(s), 4'((s * 5 + 3) & 15));
        chk_ctl("R3 pattern");

        // R4: address/data changes without strobe, and with strobe held high
        for (int i = 0; i < 16; i++) begin
            addr = 4'(i); wr_data = 4'(~i); step();
        end
        chk_ctl("R4 no strobe");
        addr = 4'd2; wr_data = 4'h9; wr_en = 1'b1; step();
        exp_ctl[8 +: 4] = 4'h9;
        for (int i = 0; i < 5; i++) begin
            addr = 4'(i); wr_data = 4'(i + 1); step();
        end
        wr_en = 1'b0; step();
        chk_ctl("R4 held strobe");

        // R5: writes to status slots ignored; status still readable
        status_in = 16'hA5C3;
        step(); step(); step();
        for (int j = 0; j < NUM_IN; j++) begin
            do_write(4'(NUM_OUT + j), 4'hF);
            chk_ctl("R5 ctl unchanged");
            do_read(4'(NUM_OUT + j), v);
            total++;
            if (v !== status_in[j*4 +: 4]) begin
                bad++;
                $display("FAIL R5 status read actual=%h expected=%h", v, status_in[j*4 +: 4]);
            end
        end

        // R6: read back every output slot
        for (int s = 0; s < NUM_OUT; s++) begin
            do_read(4'(s), v);
            total++;
            if (v !== exp_ctl[s*4 +: 4]) begin
                bad++;
                $display("FAIL R6 slot %0d actual=%h expected=%h", s, v, exp_ctl[s*4 +: 4]);
            end
        end

        // R7: synchronised status sweep, then latency check
        for (int p = 0; p < 16; p++) begin
            status_in = 16'(p * 16'h1111 ^ 16'h0F3C);
            step(); step(); step();
            for (int j = 0; j < NUM_IN; j++) begin
                do_read(4'(NUM_OUT + j), v);
                total++;
                if (v !== status_in[j*4 +: 4]) begin
                    bad++;
                    $display("FAIL R7 slot %0d actual=%h expected=%h", NUM_OUT + j, v, status_in[j*4 +: 4]);
                end
            end
        end
        status_in = 16'h1234; step(); step(); step();
        status_in = 16'h8765;
        do_read(4'(NUM_OUT), v);
        total++;
        if (v !== 4'h4) begin
            bad++;
            $display("FAIL R7 latency actual=%h expected=%h", v, 4'h4);
        end

        // R8: hold while strobe high, zero once released
        step();
        chk_rd("R8 idle", 4'h0);
        addr = 4'd1; rd_en = 1'b1; step();
        v = exp_ctl[4 +: 4];
        chk_rd("R8 first", v);
        addr = 4'd5; step(); step();
        chk_rd("R8 hold addr", v);
        wr_en = 1'b1; addr = 4'd1; wr_data = ~v; step();
        exp_ctl[4 +: 4] = ~v;
        wr_en = 1'b0; step();
        chk_rd("R8 hold data", v);
        rd_en = 1'b0; step();
        chk_rd("R8 release", 4'h0);
        chk_ctl("R2 during read");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule